// File: doc/BRIEF.md
# SDRAM Deep Power-Down Entry and Recovery Sequencer

This block takes the command bus of an SDR SDRAM away from the main memory controller for two jobs. The first is to put the device into deep power-down. The second is to bring it back out of that state. A one-cycle `reqEnter` pulse while idle makes the sequencer issue the deep power-down command: the burst-stop code with clock enable low. It then holds the device asleep, with clock enable low and chip select deasserted.

Waking the device is a fixed recovery ritual, not a single step. A `reqExit` pulse raises clock enable and waits for the clock to settle. The sequencer then precharges every bank and issues the configured number of auto-refreshes. Last, it loads the mode register from the `modeWord` input. Every command is followed by a counted run of NOP cycles. A one-cycle `done` pulse marks the moment the bus is handed back. While `busy` is high, the main controller must keep off the bus.

All timing gaps are parameters: clock-stable delay, precharge recovery, refresh cycle time, mode-register delay and refresh count.

Top module: `dpd_seq`

## Requirements
- R1: During and after reset, with no request, `cke`=1, `csN`=1, `busy`=0 and `done`=0.
- R2: A `reqEnter` sampled high while idle makes the next cycle carry the deep power-down command {cke,csN,rasN,casN,weN}=5'b00110, with `busy`=1.
- R3: After that command, every cycle until a `reqExit` is sampled shows {cke,csN,rasN,casN,weN}=5'b01111 with `busy`=1. A `reqEnter` in this period has no effect.
- R4: A `reqExit` sampled while the device is not asleep has no effect: the bus stays deselected (5'b11111) and `busy` stays 0.
- R5: In the cycle after `reqExit` is sampled, `cke` returns to 1. The bus then carries NOP (5'b10111) for STABLE_CYC cycles.
- R6: The first command after wake-up is a precharge (5'b10010) with `apBit`=1 and `bankAddr`=0. It is followed by T_RP NOP cycles.
- R7: Next come exactly NUM_REF auto-refresh commands (5'b10001, NUM_REF ≥ 2), each followed by T_RFC NOP cycles.
- R8: Next comes a mode register set (5'b10000) with `modeAddr` equal to `modeWord`, followed by T_MRD NOP cycles.
- R9: `done` is high for exactly one cycle after the mode-register wait, with `busy`=0 and the bus deselected. The block is then idle.
- R10: `busy` is high in every cycle from the deep power-down command through the last mode-register NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqEnter | input | 1 | Request to enter deep power-down |
| reqExit | input | 1 | Request to leave deep power-down |
| modeWord | input | MODE_W | Value loaded by the mode register set |
| cke | output | 1 | Clock enable to the device |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| bankAddr | output | BA_W | Bank address |
| apBit | output | 1 | All-banks / auto-precharge address bit |
| modeAddr | output | MODE_W | Address bus value, mode word during the mode set |
| busy | output | 1 | Sequencer owns the bus |
| done | output | 1 | One-cycle recovery-complete pulse |

## Verification
Every output is decoded from registered state and changes in the cycle right after the clock edge that samples a request. The deep power-down command therefore appears one edge after `reqEnter`. The recovery commands sit at fixed offsets from the edge that samples `reqExit`. With the bench parameters (3, 2, 4, 2 and two refreshes), the NOPs fill offsets 0–2, the precharge is at 3, the refreshes are at 6 and 11, the mode set is at 16, `done` is at 19 and idle returns at 20. The bench samples at each falling edge and compares each offset against a row of its expected-value table, so every check lands half a cycle after the edge that produced the value.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ENTER, ST_HOLD, ST_WAKE, ST_PRE, ST_WRP,
    ST_REF, ST_WRFC, ST_MRS, ST_WMRD, ST_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    CMD_DESEL, CMD_NOP, CMD_DPD, CMD_PRE, CMD_REF, CMD_MRS
  } cmdSel_t;

  typedef enum logic [1:0] {WS_STABLE, WS_RP, WS_RFC, WS_MRD} waitSel_t;

  typedef struct packed {
    logic     loadWait;
    waitSel_t waitSel;
    logic     loadRef;
    logic     decRef;
    cmdSel_t  cmdSel;
    logic     ckeLow;
    logic     busy;
    logic     done;
  } strobe_t;
endpackage

// File: rtl/dpd_ctrl.sv
module dpd_ctrl
  import dpd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqEnter,
  input  logic    reqExit,
  input  logic    waitZero,
  input  logic    refZero,
  output strobe_t stb
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    stb         = '0;
    stb.waitSel = WS_STABLE;
    stb.cmdSel  = CMD_NOP;
    stb.busy    = 1'b1;
    unique case (state)
      ST_IDLE: begin
        stb.cmdSel = CMD_DESEL;
        stb.busy   = 1'b0;
        if (reqEnter) nextState = ST_ENTER;
      end
      ST_ENTER: begin
        stb.cmdSel = CMD_DPD;
        stb.ckeLow = 1'b1;
        nextState  = ST_HOLD;
      end
      ST_HOLD: begin
        stb.cmdSel = CMD_DESEL;
        stb.ckeLow = 1'b1;
        if (reqExit) begin
          stb.loadWait = 1'b1;
          stb.waitSel  = WS_STABLE;
          nextState    = ST_WAKE;
        end
      end
      ST_WAKE: if (waitZero) nextState = ST_PRE;
      ST_PRE: begin
        stb.cmdSel   = CMD_PRE;
        stb.loadWait = 1'b1;
        stb.waitSel  = WS_RP;
        stb.loadRef  = 1'b1;
        nextState    = ST_WRP;
      end
      ST_WRP: if (waitZero) nextState = ST_REF;
      ST_REF: begin
        stb.cmdSel   = CMD_REF;
        stb.loadWait = 1'b1;
        stb.waitSel  = WS_RFC;
        stb.decRef   = 1'b1;
        nextState    = ST_WRFC;
      end
      ST_WRFC: if (waitZero) nextState = refZero ? ST_MRS : ST_REF;
      ST_MRS: begin
        stb.cmdSel   = CMD_MRS;
        stb.loadWait = 1'b1;
        stb.waitSel  = WS_MRD;
        nextState    = ST_WMRD;
      end
      ST_WMRD: if (waitZero) nextState = ST_DONE;
      ST_DONE: begin
        stb.cmdSel = CMD_DESEL;
        stb.busy   = 1'b0;
        stb.done   = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dpd_datapath.sv
module dpd_datapath
  import dpd_pkg::*;
#(
  parameter int STABLE_CYC = 100,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 9,
  parameter int T_MRD      = 2,
  parameter int NUM_REF    = 2,
  parameter int MODE_W     = 13,
  parameter int BA_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [MODE_W-1:0] modeWord,
  output logic              waitZero,
  output logic              refZero,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   bankAddr,
  output logic              apBit,
  output logic [MODE_W-1:0] modeAddr,
  output logic              busy,
  output logic              done
);
  localparam int MAX_A    = (STABLE_CYC > T_RFC) ? STABLE_CYC : T_RFC;
  localparam int MAX_B    = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(NUM_REF + 1);

  logic [CNT_W-1:0] waitCnt, waitLoad;
  logic [REF_W-1:0] refLeft;
  logic [3:0]       cmdBits;

  always_comb begin
    unique case (stb.waitSel)
      WS_STABLE: waitLoad = CNT_W'(STABLE_CYC - 1);
      WS_RP:     waitLoad = CNT_W'(T_RP - 1);
      WS_RFC:    waitLoad = CNT_W'(T_RFC - 1);
      default:   waitLoad = CNT_W'(T_MRD - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= '0;
    else if (stb.loadWait)  waitCnt <= waitLoad;
    else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          refLeft <= '0;
    else if (stb.loadRef)               refLeft <= REF_W'(NUM_REF);
    else if (stb.decRef && refLeft != '0) refLeft <= refLeft - 1'b1;
  end

  assign waitZero = (waitCnt == '0);
  assign refZero  = (refLeft == '0);

  // {csN, rasN, casN, weN}
  always_comb begin
    unique case (stb.cmdSel)
      CMD_NOP: cmdBits = 4'b0111;
      CMD_DPD: cmdBits = 4'b0110;
      CMD_PRE: cmdBits = 4'b0010;
      CMD_REF: cmdBits = 4'b0001;
      CMD_MRS: cmdBits = 4'b0000;
      default: cmdBits = 4'b1111;
    endcase
  end

  assign {csN, rasN, casN, weN} = cmdBits;
  assign cke      = ~stb.ckeLow;
  assign bankAddr = '0;
  assign apBit    = (stb.cmdSel == CMD_PRE);
  assign modeAddr = (stb.cmdSel == CMD_MRS) ? modeWord : '0;
  assign busy     = stb.busy;
  assign done     = stb.done;
endmodule

// File: rtl/dpd_seq.sv
module dpd_seq
  import dpd_pkg::*;
#(
  parameter int STABLE_CYC = 100,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 9,
  parameter int T_MRD      = 2,
  parameter int NUM_REF    = 2,
  parameter int MODE_W     = 13,
  parameter int BA_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqEnter,
  input  logic              reqExit,
  input  logic [MODE_W-1:0] modeWord,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   bankAddr,
  output logic              apBit,
  output logic [MODE_W-1:0] modeAddr,
  output logic              busy,
  output logic              done
);
  strobe_t stb;
  logic    waitZero, refZero;

  dpd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqEnter(reqEnter), .reqExit(reqExit),
    .waitZero(waitZero), .refZero(refZero), .stb(stb)
  );

  dpd_datapath #(
    .STABLE_CYC(STABLE_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .NUM_REF(NUM_REF), .MODE_W(MODE_W), .BA_W(BA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .modeWord(modeWord),
    .waitZero(waitZero), .refZero(refZero),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .apBit(apBit), .modeAddr(modeAddr),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/dpd_seq_chk.sv
module dpd_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cke,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic apBit,
  input logic busy,
  input logic done
);
  logic dpdCmd, preCmd, refCmd, mrsCmd, nopCmd;
  logic preSeen;
  logic [1:0] refCnt;

  assign dpdCmd = !csN &&  rasN &&  casN && !weN;
  assign preCmd = !csN && !rasN &&  casN && !weN;
  assign refCmd = !csN && !rasN && !casN &&  weN;
  assign mrsCmd = !csN && !rasN && !casN && !weN;
  assign nopCmd = !csN &&  rasN &&  casN &&  weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSeen <= 1'b0;
      refCnt  <= '0;
    end else if (dpdCmd) begin
      preSeen <= 1'b0;
      refCnt  <= '0;
    end else if (preCmd) begin
      preSeen <= 1'b1;
      refCnt  <= '0;
    end else if (refCmd && refCnt != 2'd3) begin
      refCnt  <= refCnt + 1'b1;
    end
  end

  a_r2_dpd_cke_low: assert property (@(posedge clk) disable iff (!rstN)
    dpdCmd |-> !cke);
  a_r3_asleep_deselected: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && !dpdCmd) |-> csN);
  a_r5_wake_with_nop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> nopCmd);
  a_r6_precharge_all: assert property (@(posedge clk) disable iff (!rstN)
    preCmd |-> apBit);
  a_r7_refresh_after_pre: assert property (@(posedge clk) disable iff (!rstN)
    refCmd |-> preSeen);
  a_r8_mode_after_refs: assert property (@(posedge clk) disable iff (!rstN)
    mrsCmd |-> (preSeen && refCnt >= 2'd2));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  a_r10_busy_cmds: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !nopCmd) |-> busy);
endmodule

bind dpd_seq dpd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .apBit(apBit), .busy(busy), .done(done)
);

// File: tb/dpd_seq_bench.sv
module dpd_seq_bench;
  localparam int MODE_W = 13;
  localparam int BA_W   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqEnter = 1'b0, reqExit = 1'b0;
  logic [MODE_W-1:0] modeWord = '0;
  logic cke, csN, rasN, casN, weN, apBit, busy, done;
  logic [BA_W-1:0] bankAddr;
  logic [MODE_W-1:0] modeAddr;

  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  dpd_seq #(
    .STABLE_CYC(3), .T_RP(2), .T_RFC(4), .T_MRD(2), .NUM_REF(2),
    .MODE_W(MODE_W), .BA_W(BA_W)
  ) u_dpd_seq (
    .clk(clk), .rstN(rstN), .reqEnter(reqEnter), .reqExit(reqExit),
    .modeWord(modeWord), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .apBit(apBit), .modeAddr(modeAddr),
    .busy(busy), .done(done)
  );

  // row: {req[3:0], done, busy, apBit, {cke,csN,rasN,casN,weN}}
  // index = cycles after the edge that samples reqExit
  localparam logic [11:0] EXIT_TBL [21] = '{
    {4'd5, 1'b0, 1'b1, 1'b0, 5'b10111},  // R5 clock settle
    {4'd5, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd5, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd6, 1'b0, 1'b1, 1'b1, 5'b10010},  // R6 precharge all
    {4'd6, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd6, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10001},  // R7 refresh 1
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10001},  // R7 refresh 2
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd7, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd8, 1'b0, 1'b1, 1'b0, 5'b10000},  // R8 mode set
    {4'd8, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd8, 1'b0, 1'b1, 1'b0, 5'b10111},
    {4'd9, 1'b1, 1'b0, 1'b0, 5'b11111},  // R9 done pulse
    {4'd9, 1'b0, 1'b0, 1'b0, 5'b11111}   // R9 idle again
  };

  function automatic logic [4:0] busNow();
    return {cke, csN, rasN, casN, weN};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runExit(input logic [MODE_W-1:0] mw);
    @(negedge clk);
    modeWord = mw;
    reqExit  = 1'b1;
    for (int k = 0; k < 21; k++) begin
      @(negedge clk);
      if (k == 0) reqExit = 1'b0;
      chk($sformatf("R%0d bus row %0d", EXIT_TBL[k][11:8], k),
          32'(busNow()), 32'(EXIT_TBL[k][4:0]));
      chk($sformatf("R%0d apBit row %0d", EXIT_TBL[k][11:8], k),
          32'(apBit), 32'(EXIT_TBL[k][5]));
      chk("R10 busy", 32'(busy), 32'(EXIT_TBL[k][6]));
      chk("R9 done", 32'(done), 32'(EXIT_TBL[k][7]));
      if (k == 3)  chk("R6 bankAddr zero", 32'(bankAddr), 32'd0);
      if (k == 16) chk("R8 modeAddr", 32'(modeAddr), 32'(mw));
    end
  endtask

  task automatic enterDpd();
    @(negedge clk);
    reqEnter = 1'b1;
    @(negedge clk);
    reqEnter = 1'b0;
    chk("R2 dpd command", 32'(busNow()), 32'h06);
    chk("R2 busy", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R3 asleep", 32'(busNow()), 32'h0F);
    chk("R10 busy asleep", 32'(busy), 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset bus", 32'(busNow()), 32'h1F);
    chk("R1 reset busy", 32'(busy), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle bus", 32'(busNow()), 32'h1F);
    chk("R1 idle done", 32'(done), 32'd0);

    // R4: wake request while awake is ignored
    reqExit = 1'b1;
    @(negedge clk);
    reqExit = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R4 exit ignored bus", 32'(busNow()), 32'h1F);
      chk("R4 exit ignored busy", 32'(busy), 32'd0);
    end

    enterDpd();
    // R3: further enter request while asleep changes nothing
    reqEnter = 1'b1;
    @(negedge clk);
    reqEnter = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R3 enter ignored", 32'(busNow()), 32'h0F);
    end
    runExit(13'h0123);

    // second round with a long sleep and another mode word
    enterDpd();
    repeat (20) @(negedge clk);
    chk("R3 long sleep", 32'(busNow()), 32'h0F);
    runExit(13'h1FFF);

    // R4 again after recovery: back in idle, exit ignored
    reqExit = 1'b1;
    @(negedge clk);
    reqExit = 1'b0;
    @(negedge clk);
    chk("R4 post-recovery exit ignored", 32'(busy), 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule